// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer with a small register interface. A 32-bit counter counts upward, and only on ticks of a slow functional time base. The time base reaches the block as a single-cycle enable, `tick_i`, which is synchronous to the bus clock. An optional power-of-two prescaler sits between the ticks and the counter. When the counter steps past all ones while the timer runs, the block asserts `wdt_rst_o` for a fixed number of clock cycles. It then reloads the counter from the load register. Software keeps the system alive by writing a new value to the trigger register. That write copies the load value into the counter.

The control, load, trigger and key registers are posted. A bus write only stages the value and raises a pending flag. The value takes effect on the next tick, and the flag then clears. Software must poll the pending register before it writes the same register again.

The timer can only be armed or disarmed by two ordered writes to the key register. Prescaler settings and load values written while the timer runs are held back until the next reload.

Top module: `wdt_top`

## Requirements
- R1: After reset, the pending register (0x08) and the counter (0x10) read 0 and `wdt_rst_o` is low. The ID register (0x00) returns the REV_CODE parameter in bits 7:0, with zeros above.
- R2: The timer starts counting only when the key register (0x1C) commits 0x0000BBBB and then commits 0x00004444. A lone 0x4444 has no effect.
- R3: A running timer stops only when the key register commits 0x0000AAAA and then commits 0x00005555. A lone 0x5555 leaves it running.
- R4: A committed key value that does not complete a valid pair returns the sequence to idle. For example, BBBB, then 1234, then 4444 does not start the timer.
- R5: Writes to the control register (0x0C), load register (0x14), trigger register (0x18) and key register (0x1C) each set their own pending bit. The bits are: bit 0 for control, bit 2 for load, bit 3 for trigger and bit 4 for key. A pending bit clears on the next tick, when its value commits. A write to a register whose bit is still set is dropped.
- R6: A committed trigger value that differs from the previous trigger value (0 after reset) loads the counter from the load register. An equal value leaves the counter unchanged.
- R7: Control bit 5 enables the prescaler and control bits 4:2 hold an exponent P. With the prescaler enabled, the running counter advances once per 2^P ticks. With it disabled, the counter advances on every tick. The counter never advances without a tick.
- R8: When the running counter steps from 0xFFFFFFFF, it reloads from the load register and `wdt_rst_o` goes high for exactly RST_LEN clock cycles.
- R9: While the timer runs, a committed control or load value does not change the counting rate or the count. It first takes effect at the next reload.
- R10: Bit 0 of the configuration register (0x04) is readable and writable, takes effect immediately, and reads back with all other bits zero.
- R11: While the timer is stopped, the counter holds its value except when a trigger reload occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle enable marking each functional-clock tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Byte address of the read |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| wdt_rst_o | output | 1 | Reset pulse raised on counter overflow |

## Verification
The bench sends broken key orders: a second word on its own, and a pair split by a foreign value. A design that armed on any key word would start counting in those windows, and the bench would see it. It rewrites the control register while a write is still pending and repeats a trigger value. A design that lets the late write overwrite the staged one, or reloads on any trigger write, would show the wrong control value or a jumped count. It changes the prescale exponent while the timer runs and checks that the rate stays the same until the next trigger. Across several settings it counts counter steps over fixed tick windows. It then drives the counter through the wrap and checks the reload value and the exact pulse length.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 32;
    localparam int PSC_W  = 7;
    localparam int PEND_W = 5;

    // register byte offsets
    localparam int OFF_ID    = 'h00;
    localparam int OFF_CFG   = 'h04;
    localparam int OFF_PEND  = 'h08;
    localparam int OFF_CTRL  = 'h0C;
    localparam int OFF_COUNT = 'h10;
    localparam int OFF_LOAD  = 'h14;
    localparam int OFF_TRIG  = 'h18;
    localparam int OFF_KEY   = 'h1C;

    // pending bit positions, decoded by host polling code
    localparam int PB_CTRL = 0;
    localparam int PB_LOAD = 2;
    localparam int PB_TRIG = 3;
    localparam int PB_KEY  = 4;

    localparam logic [DATA_W-1:0] KEY_ARM_1 = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_ARM_2 = 32'h0000_4444;
    localparam logic [DATA_W-1:0] KEY_DIS_1 = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_DIS_2 = 32'h0000_5555;

    typedef struct packed {
        logic       pre_en;
        logic [2:0] exp;
    } pre_cfg_t;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_ARM_HALF,
        KS_DIS_HALF
    } key_state_t;

    function automatic pre_cfg_t ctrl_decode(input logic [3:0] field);
        pre_cfg_t c;
        c.pre_en = field[3];
        c.exp    = field[2:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_encode(input pre_cfg_t c);
        return {26'b0, c.pre_en, c.exp, 2'b00};
    endfunction

    function automatic logic [PSC_W-1:0] pre_mask(input pre_cfg_t c);
        logic [PSC_W:0] full;
        full = (PSC_W+1)'(1) << c.exp;
        return PSC_W'(full - (PSC_W+1)'(1));
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [PEND_W-1:0]   pend,
    output logic                cfg_q,
    output pre_cfg_t            ctrl_q,
    output pre_cfg_t            ctrl_eff,
    output logic [DATA_W-1:0]   load_q,
    output logic [DATA_W-1:0]   load_eff,
    output logic [DATA_W-1:0]   trig_q,
    output logic                trig_fire,
    output logic                key_fire,
    output logic [DATA_W-1:0]   key_val
);

    pre_cfg_t          ctrl_s;
    logic [DATA_W-1:0] load_s, trig_s, key_s;

    always_comb begin
        ctrl_eff  = (tick && pend[PB_CTRL]) ? ctrl_s : ctrl_q;
        load_eff  = (tick && pend[PB_LOAD]) ? load_s : load_q;
        trig_fire = tick && pend[PB_TRIG] && (trig_s != trig_q);
        key_fire  = tick && pend[PB_KEY];
        key_val   = key_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            cfg_q  <= 1'b0;
            ctrl_s <= '0;
            ctrl_q <= '0;
            load_s <= '0;
            load_q <= '0;
            trig_s <= '0;
            trig_q <= '0;
            key_s  <= '0;
        end else begin
            // bus side: stage value unless an earlier write is in flight
            if (wr_en) begin
                if (wr_addr == ADDR_W'(OFF_CFG)) begin
                    cfg_q <= wr_data[0];
                end
                if (wr_addr == ADDR_W'(OFF_CTRL) && !pend[PB_CTRL]) begin
                    ctrl_s        <= ctrl_decode(wr_data[5:2]);
                    pend[PB_CTRL] <= 1'b1;
                end
                if (wr_addr == ADDR_W'(OFF_LOAD) && !pend[PB_LOAD]) begin
                    load_s        <= wr_data;
                    pend[PB_LOAD] <= 1'b1;
                end
                if (wr_addr == ADDR_W'(OFF_TRIG) && !pend[PB_TRIG]) begin
                    trig_s        <= wr_data;
                    pend[PB_TRIG] <= 1'b1;
                end
                if (wr_addr == ADDR_W'(OFF_KEY) && !pend[PB_KEY]) begin
                    key_s        <= wr_data;
                    pend[PB_KEY] <= 1'b1;
                end
            end
            // tick side: commit staged values
            if (tick) begin
                if (pend[PB_CTRL]) begin
                    ctrl_q        <= ctrl_s;
                    pend[PB_CTRL] <= 1'b0;
                end
                if (pend[PB_LOAD]) begin
                    load_q        <= load_s;
                    pend[PB_LOAD] <= 1'b0;
                end
                if (pend[PB_TRIG]) begin
                    trig_q        <= trig_s;
                    pend[PB_TRIG] <= 1'b0;
                end
                if (pend[PB_KEY]) begin
                    pend[PB_KEY] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [DATA_W-1:0] val,
    output logic              running
);

    key_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= KS_IDLE;
            running <= 1'b0;
        end else if (fire) begin
            st <= KS_IDLE;
            unique case (st)
                KS_IDLE: begin
                    if (val == KEY_ARM_1)      st <= KS_ARM_HALF;
                    else if (val == KEY_DIS_1) st <= KS_DIS_HALF;
                end
                KS_ARM_HALF: if (val == KEY_ARM_2) running <= 1'b1;
                KS_DIS_HALF: if (val == KEY_DIS_2) running <= 1'b0;
                default: st <= KS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int RST_LEN = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             running,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  pre_cfg_t         cfg_in,
    output logic [CNT_W-1:0] count,
    output logic             rst_pulse
);

    localparam int RW = $clog2(RST_LEN + 1);

    pre_cfg_t         cfg_act;
    logic [PSC_W-1:0] psc;
    logic [RW-1:0]    hold;
    logic             step;
    logic             at_max;

    always_comb begin
        at_max    = &count;
        step      = tick && running && (!cfg_act.pre_en || psc == pre_mask(cfg_act));
        rst_pulse = (hold != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            psc     <= '0;
            cfg_act <= '0;
            hold    <= '0;
        end else begin
            if (hold != '0) hold <= hold - RW'(1);
            if (reload) begin
                count   <= load_val;
                psc     <= '0;
                cfg_act <= cfg_in;
            end else if (step) begin
                psc <= '0;
                if (at_max) begin
                    count   <= load_val;
                    cfg_act <= cfg_in;
                    hold    <= RW'(RST_LEN);
                end else begin
                    count <= count + CNT_W'(1);
                end
            end else if (tick && running) begin
                psc <= psc + PSC_W'(1);
            end
            if (!running) begin
                psc     <= '0;
                cfg_act <= cfg_in;
            end
        end
    end

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          RST_LEN  = 16,
    parameter logic [7:0]  REV_CODE = 8'h31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [31:0]       rd_data_o,
    output logic              wdt_rst_o
);

    logic [PEND_W-1:0] pend_w;
    logic              cfg_w;
    pre_cfg_t          ctrl_q_w, ctrl_eff_w;
    logic [DATA_W-1:0] load_q_w, load_eff_w, trig_q_w, key_val_w, count_w;
    logic              trig_fire_w, key_fire_w, run_w;

    wdt_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .tick(tick_i),
        .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
        .pend(pend_w), .cfg_q(cfg_w), .ctrl_q(ctrl_q_w), .ctrl_eff(ctrl_eff_w),
        .load_q(load_q_w), .load_eff(load_eff_w), .trig_q(trig_q_w),
        .trig_fire(trig_fire_w), .key_fire(key_fire_w), .key_val(key_val_w)
    );

    wdt_keyseq keys_i (
        .clk(clk), .rst(rst), .fire(key_fire_w), .val(key_val_w), .running(run_w)
    );

    wdt_core #(.CNT_W(DATA_W), .RST_LEN(RST_LEN)) core_i (
        .clk(clk), .rst(rst), .tick(tick_i), .running(run_w),
        .reload(trig_fire_w), .load_val(load_eff_w), .cfg_in(ctrl_eff_w),
        .count(count_w), .rst_pulse(wdt_rst_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(OFF_ID))         rd_data_o = {24'b0, REV_CODE};
        else if (rd_addr_i == ADDR_W'(OFF_CFG))   rd_data_o = {31'b0, cfg_w};
        else if (rd_addr_i == ADDR_W'(OFF_PEND))  rd_data_o = {27'b0, pend_w};
        else if (rd_addr_i == ADDR_W'(OFF_CTRL))  rd_data_o = ctrl_encode(ctrl_q_w);
        else if (rd_addr_i == ADDR_W'(OFF_COUNT)) rd_data_o = count_w;
        else if (rd_addr_i == ADDR_W'(OFF_LOAD))  rd_data_o = load_q_w;
        else if (rd_addr_i == ADDR_W'(OFF_TRIG))  rd_data_o = trig_q_w;
    end

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [PEND_W-1:0] pend,
    input logic              running,
    input logic              reload,
    input logic              key_fire,
    input logic [DATA_W-1:0] key_val,
    input logic [DATA_W-1:0] load_eff,
    input logic [DATA_W-1:0] count,
    input logic              rst_o
);

    AST_PEND_CLEARS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (|($past(pend) & ~pend)) |-> $past(tick)); // R5
    AST_NO_STEP_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count)); // R7
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!running && !reload) |=> $stable(count)); // R11
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        reload |=> (count == $past(load_eff))); // R6
    AST_START_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> ($past(key_fire) && $past(key_val) == KEY_ARM_2)); // R2
    AST_STOP_KEY: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> ($past(key_fire) && $past(key_val) == KEY_DIS_2)); // R3
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_o) |-> (($past(count) == '1) && $past(running))); // R8
    AST_RST_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_o) |=> rst_o); // R8

endmodule

bind wdt_top wdt_chk chk_i (
    .clk(clk), .rst(rst), .tick(tick_i), .pend(pend_w), .running(run_w),
    .reload(trig_fire_w), .key_fire(key_fire_w), .key_val(key_val_w),
    .load_eff(load_eff_w), .count(count_w), .rst_o(wdt_rst_o)
);

// File: tb/wdt_top_tb.sv
module wdt_top_tb_top;

    localparam int ADDR_W  = 8;
    localparam int RST_LEN = 16;
    localparam logic [7:0] REV = 8'h31;
    localparam logic [7:0] A_ID = 8'h00, A_CFG = 8'h04, A_PEND = 8'h08, A_CTRL = 8'h0C,
                           A_CNT = 8'h10, A_LOAD = 8'h14, A_TRIG = 8'h18, A_KEY = 8'h1C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic wdt_rst;

    int checks = 0;
    int fails  = 0;
    int tdiv   = 0;

    wdt_top #(.ADDR_W(ADDR_W), .RST_LEN(RST_LEN), .REV_CODE(REV)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .wdt_rst_o(wdt_rst)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        tdiv = rst ? 0 : (tdiv + 1) % 4;
        tick = !rst && (tdiv == 0);
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tick();
        @(posedge clk);
        while (!tick) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wrp(input logic [7:0] a, input logic [31:0] d);
        wr(a, d);
        wait_tick();
    endtask

    task automatic steps(input int n, output logic [31:0] diff);
        logic [31:0] c0, c1;
        rd(A_CNT, c0);
        for (int i = 0; i < n; i++) wait_tick();
        rd(A_CNT, c1);
        diff = c1 - c0;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        rd(a, v);
        check(v == e, req, v, e);
    endtask

    task automatic expect_steps(input int n, input logic [31:0] e, input string req);
        logic [31:0] d;
        steps(n, d);
        check(d == e, req, d, e);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        check(wdt_rst == 1'b0, "R1 pulse in reset", {31'b0, wdt_rst}, 0);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_reg(A_PEND, 0, "R1 pending");
        expect_reg(A_CNT, 0, "R1 count");
        expect_reg(A_ID, {24'b0, REV}, "R1 id");
        check(wdt_rst == 1'b0, "R1 pulse", {31'b0, wdt_rst}, 0);
        // R10 config bit
        wr(A_CFG, 32'hFFFF_FFFF);
        expect_reg(A_CFG, 1, "R10 cfg");
        // R5 pending flags and dropped write
        wr(A_CTRL, 32'h24);
        expect_reg(A_PEND, 32'h01, "R5 ctrl bit0");
        wr(A_CTRL, 32'h00);
        wait_tick();
        expect_reg(A_PEND, 0, "R5 clear");
        expect_reg(A_CTRL, 32'h24, "R5 dropped write");
        wr(A_LOAD, 32'h100);
        expect_reg(A_PEND, 32'h04, "R5 load bit2");
        wait_tick();
        wr(A_TRIG, 32'h1);
        expect_reg(A_PEND, 32'h08, "R5 trig bit3");
        wait_tick();
        expect_reg(A_CNT, 32'h100, "R6 trigger reload");
        wr(A_KEY, 32'h0);
        expect_reg(A_PEND, 32'h10, "R5 key bit4");
        wait_tick();
        // R6 equal trigger ignored
        wrp(A_LOAD, 32'h200);
        wrp(A_TRIG, 32'h1);
        expect_reg(A_CNT, 32'h100, "R6 same trigger");
        wrp(A_TRIG, 32'h2);
        expect_reg(A_CNT, 32'h200, "R6 new trigger");
        // R11 stopped hold
        expect_steps(8, 0, "R11 stopped");
        // R2 lone second word; R4 broken pair
        wrp(A_KEY, 32'h4444);
        expect_steps(4, 0, "R2 lone second word");
        wrp(A_KEY, 32'hBBBB);
        wrp(A_KEY, 32'h1234);
        wrp(A_KEY, 32'h4444);
        expect_steps(4, 0, "R4 broken sequence");
        wrp(A_KEY, 32'hBBBB);
        wrp(A_KEY, 32'h4444);
        expect_steps(8, 4, "R2 started, R7 exp1");
        // R9 ctrl change deferred while running
        wrp(A_CTRL, 32'h20);
        expect_steps(8, 4, "R9 rate held");
        wrp(A_TRIG, 32'h3);
        expect_steps(8, 8, "R9 applied at reload");
        wrp(A_LOAD, 32'h300);
        expect_steps(8, 8, "R9 load deferred");
        wrp(A_TRIG, 32'h4);
        expect_reg(A_CNT, 32'h300, "R9 new load at reload");
        // R7 prescaler patterns
        wrp(A_CTRL, 32'h0C);
        wrp(A_TRIG, 32'h5);
        expect_steps(8, 8, "R7 disabled");
        wrp(A_CTRL, 32'h28);
        wrp(A_TRIG, 32'h6);
        expect_steps(8, 2, "R7 exp2");
        // R8 overflow
        wrp(A_CTRL, 32'h00);
        wrp(A_LOAD, 32'hFFFF_FFF0);
        wrp(A_TRIG, 32'h7);
        expect_reg(A_CNT, 32'hFFFF_FFF0, "R8 preload");
        for (int i = 0; i < 15; i++) wait_tick();
        expect_reg(A_CNT, 32'hFFFF_FFFF, "R8 at max");
        check(wdt_rst == 1'b0, "R8 no early pulse", {31'b0, wdt_rst}, 0);
        wait_tick();
        check(wdt_rst == 1'b1, "R8 pulse start", {31'b0, wdt_rst}, 1);
        expect_reg(A_CNT, 32'hFFFF_FFF0, "R8 wrap reload");
        begin
            int n = 0;
            while (wdt_rst && n < 100) begin
                n++;
                @(negedge clk);
            end
            check(n == RST_LEN, "R8 pulse length", n, RST_LEN);
        end
        // R3 stop
        wrp(A_LOAD, 32'h10);
        wrp(A_TRIG, 32'h8);
        wrp(A_KEY, 32'h5555);
        expect_steps(4, 4, "R3 lone second word");
        wrp(A_KEY, 32'hAAAA);
        wrp(A_KEY, 32'h5555);
        expect_steps(8, 0, "R3 stopped");
        finish_run();
    end

endmodule